// File: doc/BRIEF.md
# Register Transfer and Exchange Unit

This block carries out register-to-register copy and swap operations on a small processor register set. The set holds two 8-bit accumulators that also form one 16-bit pair, four 16-bit pointer registers, a 16-bit program counter, an 8-bit condition register and an 8-bit page register. A selector byte names the two registers. Its upper nibble is the source and its lower nibble is the destination. Moves between an 8-bit and a 16-bit register follow fixed widening and narrowing rules. Codes that name no register read as all ones, and writes to such codes are dropped.

A request is accepted on one clock edge. The block latches both operand values at that edge and then stays busy for a fixed number of idle cycles. A swap takes longer than a copy. On the last of those cycles it writes the results and gives a one-clock completion pulse. Surrounding logic preloads registers through a write port, which uses the same narrowing rules. It reads any register through a combinational debug port, which uses the same widening rules as an operand read.

Top module: `regmove_unit`

## Requirements
- R1: After a synchronous active-low reset, every register holds zero and `busy_o` and `done_o` are low.
- R2: Codes 0 to 5 name the 16-bit registers: 0 is the accumulator pair with the first accumulator in bits 15:8, 1 to 4 are the four pointers, and 5 is the program counter. These registers are read and written at full width.
- R3: Codes 8 and 9 name the first and second accumulator. Read as 16 bits, they carry 8'hFF in bits 15:8.
- R4: Codes 10 and 11 name the condition and page registers. Read as 16 bits, their byte appears in both halves.
- R5: Codes 6, 7 and 12 to 15 name no register and read as 16'hFFFF.
- R6: A write to a code that names no register changes no register.
- R7: A write to an 8-bit register stores bits 7:0 of the 16-bit value.
- R8: Copy (`op_i`=0): the destination receives the source value read at the accepting edge, and the source is unchanged. `done_o` is high in the cycle that follows the 4th rising edge after the accepting edge, and the registers hold their new values from that edge on.
- R9: Swap (`op_i`=1): both values are read at the accepting edge. The destination receives the source value and the source receives the destination value, with `done_o` after the 6th edge. Where the two codes overlap in storage, the write into the source code is applied last and wins.
- R10: `done_o` stays high for exactly one cycle. `busy_o` is high from the accepting edge up to the edge that raises `done_o`.
- R11: A start request while `busy_o` is high is ignored: it produces no extra completion, and the operation in progress is not altered.
- R12: The preload port (`ld_en_i`) writes a register while the unit is idle and has no effect while `busy_o` is high.
- R13: `dbg_data_o` shows the register named by `dbg_sel_i` under the rules of R2 to R5, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request a move; accepted when idle |
| op_i | input | 1 | 0 = copy, 1 = swap |
| sel_i | input | 8 | Source code in bits 7:4, destination code in bits 3:0 |
| ld_en_i | input | 1 | Preload write enable |
| ld_sel_i | input | 4 | Preload register code |
| ld_data_i | input | 16 | Preload value |
| dbg_sel_i | input | 4 | Debug read register code |
| dbg_data_o | output | 16 | Debug read value |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench covers moves across widths. An accumulator copied to a pointer must gain an FF upper byte, and a design that zero-extends it would show 00. A condition byte copied into the pair must appear twice. An undefined source copied to a pointer must give FFFF, and a write to an undefined destination must be dropped rather than hit the register that the low code bits would select. The bench swaps the pair with one of its own accumulators, where a design with the wrong write priority leaves the old byte in place. Completion latency is measured separately for copy and swap. The bench also issues a second start and a preload while busy; a design that restarted would give a late or extra pulse, and one that accepted the preload would corrupt a register.

// File: rtl/regmove_pkg.sv
// Package: register codes and operation type shared by the move unit.
// Assumes codes are four bits wide and come from a selector byte.
package regmove_pkg;

    localparam int CODE_W = 4;

    localparam logic [CODE_W-1:0] CODE_D  = 4'h0;
    localparam logic [CODE_W-1:0] CODE_X  = 4'h1;
    localparam logic [CODE_W-1:0] CODE_Y  = 4'h2;
    localparam logic [CODE_W-1:0] CODE_U  = 4'h3;
    localparam logic [CODE_W-1:0] CODE_S  = 4'h4;
    localparam logic [CODE_W-1:0] CODE_PC = 4'h5;
    localparam logic [CODE_W-1:0] CODE_A  = 4'h8;
    localparam logic [CODE_W-1:0] CODE_B  = 4'h9;
    localparam logic [CODE_W-1:0] CODE_CC = 4'hA;
    localparam logic [CODE_W-1:0] CODE_DP = 4'hB;

    typedef enum logic {
        OP_COPY = 1'b0,
        OP_SWAP = 1'b1
    } move_op_e;

    // True when a code names an existing register.
    function automatic logic code_defined(input logic [CODE_W-1:0] c);
        return (c <= CODE_PC) || ((c >= CODE_A) && (c <= CODE_DP));
    endfunction

endpackage

// File: rtl/regmove_rf.sv
// Module: register storage with widening read ports and narrowing write ports.
// Holds the register set; write ports are applied in index order, so
// a higher port wins where two writes touch the same storage.
// Assumes DATA_W is even; byte registers are DATA_W/2 wide.
module regmove_rf
    import regmove_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int NUM_RD = 3,
    parameter int NUM_WR = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en   [NUM_WR],
    input  logic [CODE_W-1:0] wr_sel  [NUM_WR],
    input  logic [DATA_W-1:0] wr_data [NUM_WR],
    input  logic [CODE_W-1:0] rd_sel  [NUM_RD],
    output logic [DATA_W-1:0] rd_data [NUM_RD]
);

    localparam int BYTE_W = DATA_W / 2;

    logic [BYTE_W-1:0] a_q, b_q, cc_q, dp_q;
    logic [BYTE_W-1:0] a_n, b_n, cc_n, dp_n;
    logic [DATA_W-1:0] x_q, y_q, u_q, s_q, pc_q;
    logic [DATA_W-1:0] x_n, y_n, u_n, s_n, pc_n;

    // Next state: apply each write port in order, narrowing for byte registers.
    always_comb begin
        a_n = a_q;  b_n = b_q;  cc_n = cc_q; dp_n = dp_q;
        x_n = x_q;  y_n = y_q;  u_n = u_q;   s_n = s_q;  pc_n = pc_q;
        for (int p = 0; p < NUM_WR; p++) begin
            if (wr_en[p]) begin
                case (wr_sel[p])
                    CODE_D: begin
                        a_n = wr_data[p][DATA_W-1:BYTE_W];
                        b_n = wr_data[p][BYTE_W-1:0];
                    end
                    CODE_X:  x_n  = wr_data[p];
                    CODE_Y:  y_n  = wr_data[p];
                    CODE_U:  u_n  = wr_data[p];
                    CODE_S:  s_n  = wr_data[p];
                    CODE_PC: pc_n = wr_data[p];
                    CODE_A:  a_n  = wr_data[p][BYTE_W-1:0];
                    CODE_B:  b_n  = wr_data[p][BYTE_W-1:0];
                    CODE_CC: cc_n = wr_data[p][BYTE_W-1:0];
                    CODE_DP: dp_n = wr_data[p][BYTE_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    // Storage update with synchronous reset to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= '0; b_q <= '0; cc_q <= '0; dp_q <= '0;
            x_q <= '0; y_q <= '0; u_q <= '0; s_q <= '0; pc_q <= '0;
        end else begin
            a_q <= a_n; b_q <= b_n; cc_q <= cc_n; dp_q <= dp_n;
            x_q <= x_n; y_q <= y_n; u_q <= u_n; s_q <= s_n; pc_q <= pc_n;
        end
    end

    // One widening read mux per read port.
    for (genvar g = 0; g < NUM_RD; g++) begin : g_rd
        logic [DATA_W-1:0] val;

        // Widen the selected register to DATA_W bits.
        always_comb begin
            case (rd_sel[g])
                CODE_D:  val = {a_q, b_q};
                CODE_X:  val = x_q;
                CODE_Y:  val = y_q;
                CODE_U:  val = u_q;
                CODE_S:  val = s_q;
                CODE_PC: val = pc_q;
                CODE_A:  val = {{BYTE_W{1'b1}}, a_q};
                CODE_B:  val = {{BYTE_W{1'b1}}, b_q};
                CODE_CC: val = {cc_q, cc_q};
                CODE_DP: val = {dp_q, dp_q};
                default: val = '1;
            endcase
        end

        assign rd_data[g] = val;
    end

    AST_UNDEF_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en[0] && !code_defined(wr_sel[0]) && !wr_en[NUM_WR-1])
        |=> ($stable(a_q) && $stable(b_q) && $stable(x_q) && $stable(y_q) && $stable(u_q)
             && $stable(s_q) && $stable(pc_q) && $stable(cc_q) && $stable(dp_q))); // R6

    AST_NARROW_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en[0] && (wr_sel[0] == CODE_A) && !wr_en[NUM_WR-1])
        |=> ((a_q == $past(wr_data[0][BYTE_W-1:0])) && $stable(b_q))); // R7

endmodule

// File: rtl/regmove_seq.sv
// Module: operation sequencer. Accepts a request when idle, counts the
// idle cycles for the latched operation and raises the commit strobe
// and a one-cycle done pulse. Assumes both idle counts are at least 1.
module regmove_seq
    import regmove_pkg::*;
#(
    parameter int COPY_IDLE = 4,
    parameter int SWAP_IDLE = 6
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start_i,
    input  move_op_e op_i,
    output logic     busy_o,
    output logic     done_o,
    output logic     capture_o,
    output logic     commit_o,
    output move_op_e op_o
);

    localparam int MAX_IDLE = (COPY_IDLE > SWAP_IDLE) ? COPY_IDLE : SWAP_IDLE;
    localparam int CNT_W    = $clog2(MAX_IDLE + 1);

    logic             busy_q, done_q;
    logic [CNT_W-1:0] cnt_q;
    move_op_e         op_q;

    assign capture_o = start_i && !busy_q;
    assign commit_o  = busy_q && (cnt_q == CNT_W'(1));

    // Busy flag, idle countdown, latched operation and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            cnt_q  <= '0;
            op_q   <= OP_COPY;
        end else begin
            done_q <= commit_o;
            if (capture_o) begin
                busy_q <= 1'b1;
                op_q   <= op_i;
                cnt_q  <= (op_i == OP_SWAP) ? CNT_W'(SWAP_IDLE) : CNT_W'(COPY_IDLE);
            end else if (busy_q) begin
                cnt_q <= cnt_q - CNT_W'(1);
                if (commit_o) busy_q <= 1'b0;
            end
        end
    end

    assign busy_o = busy_q;
    assign done_o = done_q;
    assign op_o   = op_q;

    // Checker counter: busy cycles since the accepting edge.
    logic [CNT_W:0] run_q;
    always_ff @(posedge clk) begin
        if (!rst_n)         run_q <= '0;
        else if (capture_o) run_q <= '0;
        else if (busy_q)    run_q <= run_q + 1'b1;
    end

    AST_IDLE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (run_q == ((op_q == OP_SWAP) ? (CNT_W+1)'(SWAP_IDLE)
                                                : (CNT_W+1)'(COPY_IDLE)))); // R8 R9

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q); // R10

    AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> done_q); // R10

    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && start_i) |=> $stable(op_q)); // R11

endmodule

// File: rtl/regmove_unit.sv
// Module: top of the register copy/swap unit. Latches the operand codes
// and values when a request is accepted, then at commit writes the
// destination (port 0) and, for a swap, the source (port 1, applied
// last). Preload writes share port 0 and are honoured only when idle.
module regmove_unit
    import regmove_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int COPY_IDLE = 4,
    parameter int SWAP_IDLE = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              op_i,
    input  logic [7:0]        sel_i,
    input  logic              ld_en_i,
    input  logic [3:0]        ld_sel_i,
    input  logic [DATA_W-1:0] ld_data_i,
    input  logic [3:0]        dbg_sel_i,
    output logic [DATA_W-1:0] dbg_data_o,
    output logic              busy_o,
    output logic              done_o
);

    localparam int NUM_RD = 3;
    localparam int NUM_WR = 2;

    logic              busy, capture, commit;
    move_op_e          op_q;
    logic [CODE_W-1:0] src_sel_q, dst_sel_q;
    logic [DATA_W-1:0] src_val_q, dst_val_q;

    logic              wr_en   [NUM_WR];
    logic [CODE_W-1:0] wr_sel  [NUM_WR];
    logic [DATA_W-1:0] wr_data [NUM_WR];
    logic [CODE_W-1:0] rd_sel  [NUM_RD];
    logic [DATA_W-1:0] rd_data [NUM_RD];

    regmove_seq #(
        .COPY_IDLE (COPY_IDLE),
        .SWAP_IDLE (SWAP_IDLE)
    ) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .op_i      (move_op_e'(op_i)),
        .busy_o    (busy),
        .done_o    (done_o),
        .capture_o (capture),
        .commit_o  (commit),
        .op_o      (op_q)
    );

    // Read ports: source operand, destination operand, debug.
    assign rd_sel[0] = sel_i[7:4];
    assign rd_sel[1] = sel_i[3:0];
    assign rd_sel[2] = dbg_sel_i;

    // Operand latch: capture codes and values at the accepting edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_sel_q <= '0;
            dst_sel_q <= '0;
            src_val_q <= '0;
            dst_val_q <= '0;
        end else if (capture) begin
            src_sel_q <= sel_i[7:4];
            dst_sel_q <= sel_i[3:0];
            src_val_q <= rd_data[0];
            dst_val_q <= rd_data[1];
        end
    end

    // Write port steering: commit writes or an idle preload.
    always_comb begin
        wr_en[0]   = commit || (ld_en_i && !busy);
        wr_sel[0]  = commit ? dst_sel_q : ld_sel_i;
        wr_data[0] = commit ? src_val_q : ld_data_i;
        wr_en[1]   = commit && (op_q == OP_SWAP);
        wr_sel[1]  = src_sel_q;
        wr_data[1] = dst_val_q;
    end

    regmove_rf #(
        .DATA_W (DATA_W),
        .NUM_RD (NUM_RD),
        .NUM_WR (NUM_WR)
    ) rf_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .rd_sel  (rd_sel),
        .rd_data (rd_data)
    );

    assign dbg_data_o = rd_data[2];
    assign busy_o     = busy;

endmodule

// File: tb/regmove_unit_tb_top.sv
// Scoreboard bench: the driver pushes expected completion cycles into a
// queue, the monitor pops them on each done pulse. Register contents are
// compared against a bench model through the debug port after each move.
module regmove_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        op_i = 1'b0;
    logic [7:0]  sel_i = '0;
    logic        ld_en_i = 1'b0;
    logic [3:0]  ld_sel_i = '0;
    logic [15:0] ld_data_i = '0;
    logic [3:0]  dbg_sel_i = '0;
    logic [15:0] dbg_data_o;
    logic        busy_o, done_o;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int exp_q[$];
    logic done_prev = 1'b0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    regmove_unit dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .sel_i(sel_i),
        .ld_en_i(ld_en_i), .ld_sel_i(ld_sel_i), .ld_data_i(ld_data_i),
        .dbg_sel_i(dbg_sel_i), .dbg_data_o(dbg_data_o), .busy_o(busy_o), .done_o(done_o)
    );

    // Bench model of the register set
    logic [7:0]  m_a = 0, m_b = 0, m_cc = 0, m_dp = 0;
    logic [15:0] m_x = 0, m_y = 0, m_u = 0, m_s = 0, m_pc = 0;

    function automatic logic [15:0] ref_rd(input logic [3:0] c);
        case (c)
            4'h0: return {m_a, m_b};
            4'h1: return m_x;
            4'h2: return m_y;
            4'h3: return m_u;
            4'h4: return m_s;
            4'h5: return m_pc;
            4'h8: return {8'hFF, m_a};
            4'h9: return {8'hFF, m_b};
            4'hA: return {m_cc, m_cc};
            4'hB: return {m_dp, m_dp};
            default: return 16'hFFFF;
        endcase
    endfunction

    task automatic ref_wr(input logic [3:0] c, input logic [15:0] v);
        case (c)
            4'h0: begin m_a = v[15:8]; m_b = v[7:0]; end
            4'h1: m_x = v;
            4'h2: m_y = v;
            4'h3: m_u = v;
            4'h4: m_s = v;
            4'h5: m_pc = v;
            4'h8: m_a = v[7:0];
            4'h9: m_b = v[7:0];
            4'hA: m_cc = v[7:0];
            4'hB: m_dp = v[7:0];
            default: ;
        endcase
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Compare every code through the debug port (R13)
    task automatic check_all(input string req);
        for (int c = 0; c < 16; c++) begin
            dbg_sel_i = 4'(c);
            #1;
            check(req, {16'h0, dbg_data_o}, {16'h0, ref_rd(4'(c))}, $sformatf("R13 code %0h", c));
        end
    endtask

    task automatic load(input logic [3:0] c, input logic [15:0] v);
        @(negedge clk);
        ld_en_i = 1'b1; ld_sel_i = c; ld_data_i = v;
        @(negedge clk);
        ld_en_i = 1'b0;
        ref_wr(c, v);
    endtask

    // Driver: issue a move, update the model, push the expected done cycle
    task automatic move(input logic swap, input logic [7:0] sel);
        logic [15:0] t1, t2;
        @(negedge clk);
        start_i = 1'b1; op_i = swap; sel_i = sel;
        @(negedge clk);
        start_i = 1'b0;
        exp_q.push_back(cyc + (swap ? 6 : 4));
        check(swap ? "R9" : "R8", {31'h0, busy_o}, 32'h1, "busy after accept");
        t1 = ref_rd(sel[7:4]);
        t2 = ref_rd(sel[3:0]);
        ref_wr(sel[3:0], t1);
        if (swap) ref_wr(sel[7:4], t2);
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (busy_o);
        @(negedge clk);
    endtask

    // Monitor: compare done timing against the scoreboard queue
    always @(negedge clk) begin
        if (rst_n) begin
            if (done_o) begin
                if (exp_q.size() == 0) begin
                    check("R11", 32'(cyc), 32'hFFFFFFFF, "done with no pending operation");
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    check("R8", 32'(cyc), 32'(e), "done cycle");
                    check("R10", {31'h0, busy_o}, 32'h0, "busy low with done");
                end
                if (done_prev) check("R10", 32'h1, 32'h0, "done longer than one cycle");
            end
            done_prev <= done_o;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state, R3 R4 R5 padding on zeroed registers
        check("R1", {30'h0, busy_o, done_o}, 32'h0, "busy/done after reset");
        check_all("R1");

        // Preloads, including narrowing and an undefined code
        load(4'h0, 16'h5678);
        load(4'h1, 16'h1234);
        load(4'h2, 16'hABCD);
        load(4'h3, 16'h0F0F);
        load(4'h4, 16'h8001);
        load(4'h5, 16'hC000);
        load(4'hA, 16'h77C5);   // R7: only C5 kept
        load(4'hB, 16'h1133);   // R7: only 33 kept
        load(4'h6, 16'hDEAD);   // R6: discarded
        check_all("R12");

        move(1'b0, 8'h12); wait_idle(); check_all("R2");    // X -> Y
        move(1'b0, 8'h81); wait_idle(); check_all("R3");    // A -> X gives FF56
        move(1'b0, 8'hA0); wait_idle(); check_all("R4");    // CC -> D gives C5C5
        move(1'b0, 8'h19); wait_idle(); check_all("R7");    // X -> B low byte
        move(1'b0, 8'h73); wait_idle(); check_all("R5");    // undefined -> U gives FFFF
        move(1'b0, 8'h4E); wait_idle(); check_all("R6");    // S -> undefined dropped
        move(1'b0, 8'h4C); wait_idle(); check_all("R6");    // S -> code C dropped
        move(1'b1, 8'h13); wait_idle(); check_all("R9");    // swap X and U
        load(4'h0, 16'h1234);
        move(1'b1, 8'h08); wait_idle(); check_all("R9");    // swap D and A: A=FF, B=12
        check("R9", {16'h0, ref_rd(4'h0)}, 32'h0000FF12, "model overlap value");
        move(1'b1, 8'hB5); wait_idle(); check_all("R9");    // swap DP and PC

        // R11 and R12: start and preload while busy are ignored
        move(1'b0, 8'h32);                                  // U -> Y
        @(negedge clk);
        start_i = 1'b1; op_i = 1'b1; sel_i = 8'h45;
        ld_en_i = 1'b1; ld_sel_i = 4'h1; ld_data_i = 16'h9999;
        @(negedge clk);
        start_i = 1'b0; ld_en_i = 1'b0;
        check("R11", {31'h0, busy_o}, 32'h1, "still busy after ignored start");
        wait_idle();
        repeat (8) @(negedge clk);
        check_all("R11");
        check("R11", 32'(exp_q.size()), 32'h0, "pending operations");

        // Back-to-back: copy issued right after a swap completes
        move(1'b1, 8'h89); wait_idle(); check_all("R9");    // swap A and B
        move(1'b0, 8'hB8); wait_idle(); check_all("R7");    // DP -> A

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule